// File: doc/BRIEF.md
# Direct-Mapped Page Translation Cache with Access Check

This block caches page translations after the segment stage has turned an effective address into a virtual segment ID. It has 64 slots, one per value of effective address bits 17..12. A slot stores the segment ID and the 16-bit page index it was filled for, plus the real page number, two protection bits, a changed flag and the real address of the page-table word that holds that changed bit. A table walker outside the block fills slots. Single-slot and whole-table invalidate commands return slots to the empty state.

Each lookup gives its result one clock later. The result is a status (translated, miss or protection fault), the real address, and possibly a request to set the changed bit in memory. The check picks the supervisor key or the problem key according to the privilege state. It then applies a fixed key-by-protection matrix to the access type. A segment-level no-execute bit rejects instruction fetches before the cache is consulted. The memory read-modify-write that the changed-bit request asks for happens outside this block. A system with separate instruction and data caches drives both with the same invalidate commands.

Top module: `ptc_page_cache`

## Requirements
- R1: The slot index is effective address bits 17..12. A fill writes the slot at its own index and replaces whatever that slot held, so a translation filled earlier at the same index then misses.
- R2: A lookup hits only when the stored segment ID equals the lookup segment ID and the stored page index equals effective address bits 27..12. Otherwise the status is miss. The all-ones segment ID is reserved to mark empty slots and is never looked up.
- R3: The outputs appear in the cycle after the lookup is presented. `rsp_valid` is high for exactly that cycle. Status codes are 0 = translated, 1 = miss, 2 = protection fault, and code 3 never appears.
- R4: On status 0 the real address is the stored 20-bit real page number followed by effective address bits 11..0. On any other status the address is zero.
- R5: The key used is `lk_key_sup` when `lk_problem` is 0 and `lk_key_prob` when `lk_problem` is 1. The other key has no effect.
- R6: Access codes are 0 = data read, 1 = data write, 2 = instruction fetch, and 3 behaves as a data read. With key 0, every access is allowed except a data write to protection 3.
- R7: With key 1, protection 0 denies every access, protection 1 and 3 allow reads and fetches but deny writes, and protection 2 allows everything.
- R8: When `lk_noexec` is set, an instruction fetch returns status 2 whether the cache holds the page or not. Data accesses ignore `lk_noexec`.
- R9: A permitted data write that hits a slot with its changed flag clear pulses `chg_req` with `chg_addr` equal to the slot's stored word address. It also sets the slot's changed flag, so later writes issue no request. Reads, fetches, denied writes and writes to a slot whose flag is already set issue no request.
- R10: `inv_one` empties only the slot selected by bits 17..12 of `inv_ea`. All other slots keep their translations.
- R11: `inv_all` and reset empty every slot. An invalidate takes priority over a fill presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vsid | input | 24 | Virtual segment ID from the segment stage |
| lk_ea | input | 32 | Effective address |
| lk_acc | input | 2 | Access type (0 read, 1 write, 2 fetch) |
| lk_key_sup | input | 1 | Supervisor-state key |
| lk_key_prob | input | 1 | Problem-state key |
| lk_noexec | input | 1 | Segment forbids instruction fetch |
| lk_problem | input | 1 | Processor in problem state |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vsid | input | 24 | Segment ID tag to store |
| fill_ea | input | 32 | Effective address whose page is filled |
| fill_rpn | input | 20 | Real page number |
| fill_pp | input | 2 | Protection bits |
| fill_chg | input | 1 | Changed flag as read from the page table |
| fill_waddr | input | 32 | Real address of the word holding the changed bit |
| inv_one | input | 1 | Invalidate one slot |
| inv_ea | input | 32 | Address selecting the slot to invalidate |
| inv_all | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_stat | output | 2 | Result status |
| rsp_ra | output | 32 | Real address |
| chg_req | output | 1 | Request to set the changed bit in memory |
| chg_addr | output | 32 | Word address for that request |

## Verification
The hardest case to reach from the ports is the changed-bit handshake. It needs a slot filled with its flag clear, then a write that both hits and passes the permission matrix, then a second write whose request must be suppressed because of the flag the first write set. The bench builds this sequence directly with fills and back-to-back writes. It also shows that denied writes and reads leave the flag clear. It sweeps the full matrix of privilege state, selected key, opposite key, protection value and access type on one slot. It also forces slot replacement by filling a second page at the same index, and it overlaps an invalidate with a fill to confirm the invalidate wins.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_MISS = 2'd1,
    ST_PROT = 2'd2
  } stat_e;

  // key-by-protection matrix; fetch and reserved behave as reads
  function automatic logic perm_ok(input logic key, input logic [1:0] pp,
                                   input logic [1:0] acc);
    logic is_wr;
    is_wr = (acc == ACC_WRITE);
    if (!key) begin
      perm_ok = !(is_wr && pp == 2'b11);
    end else begin
      case (pp)
        2'b00:   perm_ok = 1'b0;
        2'b10:   perm_ok = 1'b1;
        default: perm_ok = !is_wr;
      endcase
    end
  endfunction

  function automatic logic pick_key(input logic problem, input logic ks,
                                    input logic kp);
    pick_key = problem ? kp : ks;
  endfunction

endpackage

// File: rtl/ptc_store.sv
module ptc_store #(
  parameter int VSID_W = 24,
  parameter int PIDX_W = 16,
  parameter int RPN_W  = 20,
  parameter int PA_W   = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  // read port
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [VSID_W-1:0] rd_vsid,
  input  logic [PIDX_W-1:0] rd_pidx,
  output logic              rd_hit,
  output logic [RPN_W-1:0]  rd_rpn,
  output logic [1:0]        rd_pp,
  output logic              rd_chg,
  output logic [PA_W-1:0]   rd_waddr,
  // writes
  input  logic              wr_fill,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VSID_W-1:0] wr_vsid,
  input  logic [PIDX_W-1:0] wr_pidx,
  input  logic [RPN_W-1:0]  wr_rpn,
  input  logic [1:0]        wr_pp,
  input  logic              wr_chg,
  input  logic [PA_W-1:0]   wr_waddr,
  input  logic              set_chg,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              kill_one,
  input  logic [IDX_W-1:0]  kill_idx,
  input  logic              kill_all
);
  localparam int DEPTH = 1 << IDX_W;

  logic [VSID_W-1:0] t_vsid  [DEPTH];
  logic [PIDX_W-1:0] t_pidx  [DEPTH];
  logic [RPN_W-1:0]  d_rpn   [DEPTH];
  logic [1:0]        d_pp    [DEPTH];
  logic              d_chg   [DEPTH];
  logic [PA_W-1:0]   d_waddr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_fill, hit_kill, hit_set;
    assign hit_fill = wr_fill  && (wr_idx   == IDX_W'(g));
    assign hit_kill = kill_all || (kill_one && (kill_idx == IDX_W'(g)));
    assign hit_set  = set_chg  && (set_idx  == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        t_vsid[g]  <= '1;
        t_pidx[g]  <= '0;
        d_rpn[g]   <= '0;
        d_pp[g]    <= '0;
        d_chg[g]   <= 1'b0;
        d_waddr[g] <= '0;
      end else if (hit_kill) begin
        t_vsid[g]  <= '1;
      end else if (hit_fill) begin
        t_vsid[g]  <= wr_vsid;
        t_pidx[g]  <= wr_pidx;
        d_rpn[g]   <= wr_rpn;
        d_pp[g]    <= wr_pp;
        d_chg[g]   <= wr_chg;
        d_waddr[g] <= wr_waddr;
      end else if (hit_set) begin
        d_chg[g]   <= 1'b1;
      end
    end
  end

  assign rd_hit   = (t_vsid[rd_idx] == rd_vsid) && (t_pidx[rd_idx] == rd_pidx);
  assign rd_rpn   = d_rpn[rd_idx];
  assign rd_pp    = d_pp[rd_idx];
  assign rd_chg   = d_chg[rd_idx];
  assign rd_waddr = d_waddr[rd_idx];

  // R11
  wipe_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kill_all) |-> (t_vsid[rd_idx] == '1));

endmodule

// File: rtl/ptc_check.sv
module ptc_check
  import ptc_pkg::*;
(
  input  logic       hit,
  input  logic [1:0] acc,
  input  logic       key_sup,
  input  logic       key_prob,
  input  logic       problem,
  input  logic       noexec,
  input  logic [1:0] pp,
  input  logic       chg,
  output logic [1:0] stat,
  output logic       need_chg,
  output logic       nx_block,
  output logic       key_eff
);
  logic allowed;

  assign key_eff  = pick_key(problem, key_sup, key_prob);
  assign nx_block = noexec && (acc == ACC_FETCH);
  assign allowed  = perm_ok(key_eff, pp, acc);

  always_comb begin
    if (nx_block)     stat = ST_PROT;
    else if (!hit)    stat = ST_MISS;
    else if (!allowed) stat = ST_PROT;
    else              stat = ST_OK;
  end

  assign need_chg = (stat == ST_OK) && (acc == ACC_WRITE) && !chg;

endmodule

// File: rtl/ptc_page_cache.sv
module ptc_page_cache
  import ptc_pkg::*;
#(
  parameter int VSID_W = 24,
  parameter int EA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PIDX_W = 16,
  parameter int IDX_W  = 6,
  parameter int PA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VSID_W-1:0] lk_vsid,
  input  logic [EA_W-1:0]   lk_ea,
  input  logic [1:0]        lk_acc,
  input  logic              lk_key_sup,
  input  logic              lk_key_prob,
  input  logic              lk_noexec,
  input  logic              lk_problem,
  input  logic              fill_valid,
  input  logic [VSID_W-1:0] fill_vsid,
  input  logic [EA_W-1:0]   fill_ea,
  input  logic [EA_W-OFF_W-1:0] fill_rpn,
  input  logic [1:0]        fill_pp,
  input  logic              fill_chg,
  input  logic [PA_W-1:0]   fill_waddr,
  input  logic              inv_one,
  input  logic [EA_W-1:0]   inv_ea,
  input  logic              inv_all,
  output logic              rsp_valid,
  output logic [1:0]        rsp_stat,
  output logic [EA_W-1:0]   rsp_ra,
  output logic              chg_req,
  output logic [PA_W-1:0]   chg_addr
);
  localparam int RPN_W = EA_W - OFF_W;

  function automatic logic [IDX_W-1:0] slot_of(input logic [EA_W-1:0] ea);
    slot_of = ea[OFF_W +: IDX_W];
  endfunction

  function automatic logic [PIDX_W-1:0] page_of(input logic [EA_W-1:0] ea);
    page_of = ea[OFF_W +: PIDX_W];
  endfunction

  logic              s_hit, s_chg, c_need, c_nx, c_key;
  logic [RPN_W-1:0]  s_rpn;
  logic [1:0]        s_pp, c_stat;
  logic [PA_W-1:0]   s_waddr;
  logic              mark_chg;

  assign mark_chg = lk_valid && c_need;

  ptc_store #(.VSID_W(VSID_W), .PIDX_W(PIDX_W), .RPN_W(RPN_W),
              .PA_W(PA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(slot_of(lk_ea)), .rd_vsid(lk_vsid), .rd_pidx(page_of(lk_ea)),
    .rd_hit(s_hit), .rd_rpn(s_rpn), .rd_pp(s_pp), .rd_chg(s_chg),
    .rd_waddr(s_waddr),
    .wr_fill(fill_valid), .wr_idx(slot_of(fill_ea)), .wr_vsid(fill_vsid),
    .wr_pidx(page_of(fill_ea)), .wr_rpn(fill_rpn), .wr_pp(fill_pp),
    .wr_chg(fill_chg), .wr_waddr(fill_waddr),
    .set_chg(mark_chg), .set_idx(slot_of(lk_ea)),
    .kill_one(inv_one), .kill_idx(slot_of(inv_ea)), .kill_all(inv_all)
  );

  ptc_check u_check (
    .hit(s_hit), .acc(lk_acc), .key_sup(lk_key_sup), .key_prob(lk_key_prob),
    .problem(lk_problem), .noexec(lk_noexec), .pp(s_pp), .chg(s_chg),
    .stat(c_stat), .need_chg(c_need), .nx_block(c_nx), .key_eff(c_key)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_stat  <= ST_OK;
      rsp_ra    <= '0;
      chg_req   <= 1'b0;
      chg_addr  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_stat  <= lk_valid ? c_stat : ST_OK;
      rsp_ra    <= (lk_valid && c_stat == ST_OK) ?
                   {s_rpn, lk_ea[OFF_W-1:0]} : '0;
      chg_req   <= mark_chg;
      chg_addr  <= mark_chg ? s_waddr : '0;
    end
  end

  // R3
  stat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_stat != 2'd3));

  // R8
  nx_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_noexec && lk_acc == ACC_FETCH) |=> (rsp_stat == ST_PROT));

  // R7
  key1_pp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && s_hit && !c_nx && c_key && s_pp == 2'b00) |=> (rsp_stat == ST_PROT));

  // R9
  chg_only_ok_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_req |-> (rsp_valid && rsp_stat == ST_OK && $past(lk_acc) == ACC_WRITE));

  // R4
  ra_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_stat != ST_OK) |-> (rsp_ra == '0));

endmodule

// File: tb/sim_ptc_page_cache.sv
module sim_ptc_page_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        lk_valid = 0, lk_key_sup = 0, lk_key_prob = 0, lk_noexec = 0, lk_problem = 0;
  logic [23:0] lk_vsid = 0;
  logic [31:0] lk_ea = 0;
  logic [1:0]  lk_acc = 0;
  logic        fill_valid = 0, fill_chg = 0;
  logic [23:0] fill_vsid = 0;
  logic [31:0] fill_ea = 0, fill_waddr = 0;
  logic [19:0] fill_rpn = 0;
  logic [1:0]  fill_pp = 0;
  logic        inv_one = 0, inv_all = 0;
  logic [31:0] inv_ea = 0;
  logic        rsp_valid, chg_req;
  logic [1:0]  rsp_stat;
  logic [31:0] rsp_ra, chg_addr;

  ptc_page_cache u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input [23:0] v, input [31:0] ea, input [19:0] rpn,
                      input [1:0] pp, input bit c, input [31:0] wa);
    @(negedge clk);
    fill_valid = 1; fill_vsid = v; fill_ea = ea; fill_rpn = rpn;
    fill_pp = pp; fill_chg = c; fill_waddr = wa;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic look(input [23:0] v, input [31:0] ea, input [1:0] acc,
                      input bit ks, input bit kp, input bit prob, input bit nx);
    @(negedge clk);
    lk_valid = 1; lk_vsid = v; lk_ea = ea; lk_acc = acc;
    lk_key_sup = ks; lk_key_prob = kp; lk_problem = prob; lk_noexec = nx;
    @(posedge clk);
    #1;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic look_stat(input [23:0] v, input [31:0] ea, input [1:0] acc,
                           input [1:0] exp, input string req);
    look(v, ea, acc, 0, 0, 0, 0);
    chk(rsp_stat == exp, req, rsp_stat, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // reset: empty and quiet (R11, R3)
    chk(rsp_valid == 0, "R3 reset valid", rsp_valid, 0);
    look_stat(24'h0, 32'h0, 0, 1, "R11 reset miss");
    look_stat(24'h5, 32'h0123_4000, 0, 1, "R11 reset miss2");

    // R3/R4 basic translation and latency
    fill(24'h00ABCD, 32'h0123_4000, 20'hBEEF1, 2'b10, 1, 32'h1000);
    @(negedge clk);
    lk_valid = 1; lk_vsid = 24'h00ABCD; lk_ea = 32'h0123_4A5C; lk_acc = 0;
    lk_key_sup = 0; lk_key_prob = 0; lk_problem = 0; lk_noexec = 0;
    #1 chk(rsp_valid == 0, "R3 no early result", rsp_valid, 0);
    @(posedge clk); #1;
    chk(rsp_valid == 1, "R3 valid next cycle", rsp_valid, 1);
    chk(rsp_stat == 0, "R3 ok status", rsp_stat, 0);
    chk(rsp_ra == 32'hBEEF_1A5C, "R4 real address", rsp_ra, 32'hBEEF_1A5C);
    @(negedge clk) lk_valid = 0;
    @(posedge clk); #1;
    chk(rsp_valid == 0, "R3 single pulse", rsp_valid, 0);

    // R2 mismatches
    look_stat(24'h00ABCE, 32'h0123_4000, 0, 1, "R2 vsid mismatch");
    look_stat(24'h00ABCD, 32'h0523_4000, 0, 1, "R2 page upper mismatch");
    chk(rsp_ra == 0, "R4 miss ra zero", rsp_ra, 0);

    // R1 replacement at same index (bits 17..12 = 0x34 & 0x3f)
    fill(24'h00ABCD, 32'h0163_4000, 20'h22222, 2'b10, 1, 32'h2000);
    look_stat(24'h00ABCD, 32'h0123_4000, 0, 1, "R1 replaced misses");
    look_stat(24'h00ABCD, 32'h0163_4000, 0, 0, "R1 new hits");

    // R5/R6/R7 exhaustive matrix
    for (int pp = 0; pp < 4; pp++) begin
      fill(24'h000077, 32'h0007_7000, 20'h77777, pp[1:0], 1, 32'h3000);
      for (int prob = 0; prob < 2; prob++)
        for (int key = 0; key < 2; key++)
          for (int acc = 0; acc < 4; acc++) begin
            bit wr, ok;
            logic [1:0] e;
            wr = (acc == 1);
            if (key == 0) ok = !(wr && pp == 3);
            else ok = (pp == 2) || (pp != 0 && !wr);
            e = ok ? 2'd0 : 2'd2;
            look(24'h000077, 32'h0007_7123, acc[1:0],
                 prob ? !key[0] : key[0], prob ? key[0] : !key[0], prob[0], 0);
            chk(rsp_stat == e, key ? "R7 key1 matrix (R5 select)" : "R6 key0 matrix (R5 select)",
                rsp_stat, e);
            chk(rsp_ra == (ok ? 32'h7777_7123 : 32'h0), "R4 ra in matrix",
                rsp_ra, ok ? 32'h7777_7123 : 32'h0);
          end
    end

    // R8 no-execute
    look(24'h000077, 32'h0007_7000, 2, 0, 0, 0, 1);
    chk(rsp_stat == 2, "R8 nx fetch hit", rsp_stat, 2);
    look(24'h000999, 32'h0009_9000, 2, 0, 0, 0, 1);
    chk(rsp_stat == 2, "R8 nx fetch miss", rsp_stat, 2);
    look(24'h000077, 32'h0007_7000, 0, 0, 0, 0, 1);
    chk(rsp_stat == 0, "R8 nx data read", rsp_stat, 0);

    // R9 changed-bit handshake
    fill(24'h000011, 32'h0001_1000, 20'h11111, 2'b10, 0, 32'hCAFE_0008);
    look(24'h000011, 32'h0001_1004, 0, 0, 0, 0, 0);
    chk(chg_req == 0, "R9 read no request", chg_req, 0);
    look(24'h000011, 32'h0001_1004, 1, 0, 0, 0, 0);
    chk(chg_req == 1, "R9 first write request", chg_req, 1);
    chk(chg_addr == 32'hCAFE_0008, "R9 request address", chg_addr, 32'hCAFE_0008);
    look(24'h000011, 32'h0001_1004, 1, 0, 0, 0, 0);
    chk(chg_req == 0, "R9 second write silent", chg_req, 0);
    fill(24'h000012, 32'h0001_2000, 20'h12121, 2'b11, 0, 32'h0000_0040);
    look(24'h000012, 32'h0001_2000, 1, 0, 0, 0, 0);
    chk(chg_req == 0, "R9 denied write silent", chg_req, 0);
    fill(24'h000012, 32'h0001_2000, 20'h12121, 2'b10, 1, 32'h0000_0040);
    look(24'h000012, 32'h0001_2000, 1, 0, 0, 0, 0);
    chk(chg_req == 0, "R9 flag set silent", chg_req, 0);

    // R10 single invalidate
    fill(24'h000021, 32'h0002_1000, 20'h21212, 2'b10, 1, 0);
    @(negedge clk) begin inv_one = 1; inv_ea = 32'hFFF2_1FFF; end
    @(negedge clk) inv_one = 0;
    look_stat(24'h000021, 32'h0002_1000, 0, 1, "R10 target emptied");
    look_stat(24'h000011, 32'h0001_1000, 0, 0, "R10 neighbour kept");

    // R11 invalidate all, and priority over fill
    @(negedge clk) inv_all = 1;
    @(negedge clk) inv_all = 0;
    look_stat(24'h000011, 32'h0001_1000, 0, 1, "R11 all emptied a");
    look_stat(24'h000077, 32'h0007_7000, 0, 1, "R11 all emptied b");
    @(negedge clk);
    fill_valid = 1; fill_vsid = 24'h000031; fill_ea = 32'h0003_1000;
    fill_rpn = 20'h31313; fill_pp = 2; fill_chg = 1; inv_one = 1; inv_ea = 32'h0003_1000;
    @(negedge clk) begin fill_valid = 0; inv_one = 0; end
    look_stat(24'h000031, 32'h0003_1000, 0, 1, "R11 invalidate beats fill");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule